// File: doc/BRIEF.md
# Secondary Core Boot Controller

This block keeps a set of secondary processor cores parked in halt and hands each one the address it starts from when it is let go. Software reaches it over a simple single-cycle write/read register bus. A halt register carries one bit per physical core. Each core also has its own two-word boot-address slot, one upper word and one lower word. A small logical-to-physical map lets software name a core by its logical number. Through a dedicated single-bit write port, software can halt or release that one core without touching any other core's bit.

When a halt bit falls from 1 to 0, the block pulses a one-cycle release strobe for that core. In the same edge it copies the core's two boot words into a 64-bit boot vector. The vector then stays fixed while the core runs, even if software rewrites the words. A request to halt a running core is held back until the core reports that its power-down has finished. A later release request for that core cancels the held request.

The boot sequence for one core goes as follows. Software writes 0 to the upper word and the start address to the lower word, then clears the core's halt bit.

Top module: `core_boot_ctrl`

## Requirements
- R1: After reset every halt bit is 1, every boot word and every boot vector is 0, no release strobe is active, rdData is 0 and the map holds the identity (logical i maps to physical i).
- R2: The halt register sits at offset 0x00. Bit p belongs to physical core p, and 1 means halted while 0 means running. A write of 0 to bit p releases core p, and a write of 1 asks for halt. Reads return the current halt bits.
- R3: The single-bit port sits at offset 0x08. In a write, wrData[7:0] is the logical core number and wrData[8] is the new halt value. The write changes only the halt bit of the physical core that the map gives, and leaves every other bit as it was. A logical number of NUM_CORES or more is ignored.
- R4: The map register sits at offset 0x04. Logical entry i occupies bits [2i+1:2i] and holds a physical core number. It can be written and read back.
- R5: The boot words of physical core p sit at 0x40 + 8p (upper word) and 0x44 + 8p (lower word). Both can be written and read back.
- R6: coreRelease[p] is high for exactly one cycle, in the same cycle that coreHalt[p] first reads 0 after being 1. It is high at no other time.
- R7: On release, bootVec[p] takes the value {upper word, lower word} held before that edge. It then keeps that value until the next release of the same core, whatever is written in between.
- R8: A halt request for a running core takes effect only in a cycle where coreOff[p] is 1. Until then it is held pending. A release request for that core clears a pending request, and it wins over a halt that would take effect in the same cycle.
- R9: A read of an offset that is unmapped or not word-aligned returns 0, and so does a read of offset 0x08. A write to an unmapped or unaligned offset changes nothing.
- R10: rdData shows the addressed register from the edge that samples rdEn. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| coreOff | input | NUM_CORES | Per-core power-down-finished status |
| coreHalt | output | NUM_CORES | Per-core halt (1 = held) |
| coreRelease | output | NUM_CORES | One-cycle release strobe per core |
| bootVec | output | 64*NUM_CORES | Captured 64-bit boot vector per core, core p at bits [64p+63:64p] |

## Verification
The halt register can be changed in a single cycle both by a bus write and by a held halt request that completes when coreOff rises. The bench provokes this overlap in two ways. In the first, it raises coreOff of one core that has a halt pending while, on the same edge, it releases a different core through the single-bit port. Both effects must then appear together: the first core halted, the second released with its strobe, and the remaining bits unchanged. In the second, the release targets the very core whose coreOff rises, and there the core must stay running, with no strobe and nothing left pending.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_HALT    = 3'd1,
    RD_MAP     = 3'd2,
    RD_BOOT_HI = 3'd3,
    RD_BOOT_LO = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrHalt;
    logic   wrMap;
    logic   wrLogical;
    logic   wrBootHi;
    logic   wrBootLo;
    logic   rdStb;
    rdSel_e rdSel;
  } strobe_t;

  localparam int LOGICAL_IDX_W = 8;
  localparam int LOGICAL_VAL_BIT = 8;

endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] HALT_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] MAP_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] LOGIC_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 8'h40
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  bootIdx
);

  localparam logic [ADDR_W-1:0] BOOT_SPAN = ADDR_W'(NUM_CORES * 8);

  logic              aligned;
  logic              inBoot;
  logic              isLower;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    offs    = addr - BOOT_BASE;
    inBoot  = aligned && (addr >= BOOT_BASE) && (offs < BOOT_SPAN);
    isLower = offs[2];
    bootIdx = offs[IDX_W+2:3];
  end

  always_comb begin
    stb           = '0;
    stb.rdSel     = RD_NONE;
    stb.rdStb     = rdEn;
    stb.wrHalt    = wrEn && (addr == HALT_OFS);
    stb.wrMap     = wrEn && (addr == MAP_OFS);
    stb.wrLogical = wrEn && (addr == LOGIC_OFS);
    stb.wrBootHi  = wrEn && inBoot && !isLower;
    stb.wrBootLo  = wrEn && inBoot && isLower;
    if (inBoot) begin
      stb.rdSel = isLower ? RD_BOOT_LO : RD_BOOT_HI;
    end else if (addr == HALT_OFS) begin
      stb.rdSel = RD_HALT;
    end else if (addr == MAP_OFS) begin
      stb.rdSel = RD_MAP;
    end
  end

endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [IDX_W-1:0]          bootIdx,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_CORES-1:0]      coreOff,
  output logic [NUM_CORES-1:0]      coreHalt,
  output logic [NUM_CORES-1:0]      coreRelease,
  output logic [2*DATA_W*NUM_CORES-1:0] bootVec,
  output logic [DATA_W-1:0]         rdData
);

  localparam int MAP_W = NUM_CORES * IDX_W;
  localparam int VEC_W = 2 * DATA_W;
  localparam logic [LOGICAL_IDX_W-1:0] NUM_L = LOGICAL_IDX_W'(NUM_CORES);

  function automatic logic [MAP_W-1:0] identityMap();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      m[i*IDX_W +: IDX_W] = IDX_W'(i);
    end
    return m;
  endfunction

  logic [MAP_W-1:0]          mapQ;
  logic [DATA_W-1:0]         rdQ;
  logic [DATA_W-1:0]         rdNext;
  logic [DATA_W-1:0]         hiAll [NUM_CORES];
  logic [DATA_W-1:0]         loAll [NUM_CORES];
  logic [NUM_CORES-1:0]      setReq;
  logic [NUM_CORES-1:0]      clrReq;
  logic [LOGICAL_IDX_W-1:0]  logIdx;
  logic                      logVal;
  logic                      logValid;
  logic [IDX_W-1:0]          physSel;

  // Logical-to-physical resolution of the single-bit halt port
  always_comb begin
    logIdx   = wrData[LOGICAL_IDX_W-1:0];
    logVal   = wrData[LOGICAL_VAL_BIT];
    logValid = (logIdx < NUM_L);
    physSel  = mapQ[logIdx[IDX_W-1:0]*IDX_W +: IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapQ <= identityMap();
    end else if (stb.wrMap) begin
      mapQ <= wrData[MAP_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_CORES; p++) begin : gCore
    logic              haltR;
    logic              pendR;
    logic              relR;
    logic              hitL;
    logic [VEC_W-1:0]  vecR;
    logic [DATA_W-1:0] hiR;
    logic [DATA_W-1:0] loR;

    always_comb begin
      hitL      = stb.wrLogical && logValid && (physSel == IDX_W'(p));
      clrReq[p] = (stb.wrHalt && !wrData[p]) || (hitL && !logVal);
      setReq[p] = (stb.wrHalt && wrData[p]) || (hitL && logVal);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        haltR <= 1'b1;
        pendR <= 1'b0;
        relR  <= 1'b0;
        vecR  <= '0;
      end else begin
        relR <= clrReq[p] && haltR;
        if (clrReq[p] && haltR) begin
          vecR <= {hiR, loR};
        end
        if (clrReq[p]) begin
          haltR <= 1'b0;
          pendR <= 1'b0;
        end else if (setReq[p] || pendR) begin
          if (coreOff[p]) begin
            haltR <= 1'b1;
            pendR <= 1'b0;
          end else if (!haltR) begin
            pendR <= 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiR <= '0;
        loR <= '0;
      end else begin
        if (stb.wrBootHi && (bootIdx == IDX_W'(p))) hiR <= wrData;
        if (stb.wrBootLo && (bootIdx == IDX_W'(p))) loR <= wrData;
      end
    end

    assign hiAll[p]                  = hiR;
    assign loAll[p]                  = loR;
    assign coreHalt[p]               = haltR;
    assign coreRelease[p]            = relR;
    assign bootVec[p*VEC_W +: VEC_W] = vecR;
  end

  always_comb begin
    case (stb.rdSel)
      RD_HALT:    rdNext = DATA_W'(coreHalt);
      RD_MAP:     rdNext = DATA_W'(mapQ);
      RD_BOOT_HI: rdNext = hiAll[bootIdx];
      RD_BOOT_LO: rdNext = loAll[bootIdx];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (stb.rdStb) begin
      rdQ <= rdNext;
    end
  end

  assign rdData = rdQ;

endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import cbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] HALT_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] MAP_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] LOGIC_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 8'h40
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  input  logic [NUM_CORES-1:0]          coreOff,
  output logic [NUM_CORES-1:0]          coreHalt,
  output logic [NUM_CORES-1:0]          coreRelease,
  output logic [2*DATA_W*NUM_CORES-1:0] bootVec
);

  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  strobe_t          stb;
  logic [IDX_W-1:0] bootIdx;

  cbc_ctrl #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W(ADDR_W),
    .IDX_W(IDX_W),
    .HALT_OFS(HALT_OFS),
    .MAP_OFS(MAP_OFS),
    .LOGIC_OFS(LOGIC_OFS),
    .BOOT_BASE(BOOT_BASE)
  ) uCtrl (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb(stb),
    .bootIdx(bootIdx)
  );

  cbc_datapath #(
    .NUM_CORES(NUM_CORES),
    .DATA_W(DATA_W),
    .IDX_W(IDX_W)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .bootIdx(bootIdx),
    .wrData(wrData),
    .coreOff(coreOff),
    .coreHalt(coreHalt),
    .coreRelease(coreRelease),
    .bootVec(bootVec),
    .rdData(rdData)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          rdEn,
  input logic [DATA_W-1:0]             rdData,
  input logic [NUM_CORES-1:0]          coreOff,
  input logic [NUM_CORES-1:0]          coreHalt,
  input logic [NUM_CORES-1:0]          coreRelease,
  input logic [2*DATA_W*NUM_CORES-1:0] bootVec
);

  localparam int VEC_W = 2 * DATA_W;

  // R6: the strobe marks exactly the cycles in which a halt bit has just fallen
  a_r6_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (($past(coreHalt) & ~coreHalt) == coreRelease));

  // R8: a halt bit rises only after that core reported power-down
  a_r8_halt_after_off: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(coreHalt) & coreHalt & ~$past(coreOff)) == '0));

  // R10: read data moves only after a read was sampled
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData));

  for (genvar p = 0; p < NUM_CORES; p++) begin : gChk
    // R7: a running core's vector does not move except on its release
    a_r7_vec_stable: assert property (@(posedge clk) disable iff (!rstN)
      (!coreRelease[p] && !$past(coreHalt[p])) |-> $stable(bootVec[p*VEC_W +: VEC_W]));
  end

endmodule

bind core_boot_ctrl cbc_checker #(
  .NUM_CORES(NUM_CORES),
  .DATA_W(DATA_W)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .rdEn(rdEn),
  .rdData(rdData),
  .coreOff(coreOff),
  .coreHalt(coreHalt),
  .coreRelease(coreRelease),
  .bootVec(bootVec)
);

// File: tb/core_boot_ctrl_test.sv
module core_boot_ctrl_test;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  coreOff = '1;
  logic [N-1:0]  coreHalt;
  logic [N-1:0]  coreRelease;
  logic [64*N-1:0] bootVec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic pendRd = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  core_boot_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .coreOff(coreOff),
    .coreHalt(coreHalt), .coreRelease(coreRelease), .bootVec(bootVec)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard of read results
  always @(posedge clk) pendRd <= rdEn;

  always @(negedge clk) begin
    if (pendRd) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected read actual=%h expected=none", rdData);
      end else begin
        chk({32'h0, rdData}, {32'h0, expQ.pop_front()}, tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(64'(coreHalt), 64'hF, "R1 halt after reset");
    chk(64'(coreRelease), 64'h0, "R1 release after reset");
    chk(64'(bootVec[63:0] | bootVec[127:64] | bootVec[191:128] | bootVec[255:192]), 64'h0, "R1 vectors after reset");
    chk(64'(rdData), 64'h0, "R1 rdData after reset");
    rd(8'h00, 32'hF, "R1 R2 halt reg reset");
    rd(8'h04, 32'hE4, "R1 R4 identity map");
    rd(8'h40, 32'h0, "R1 boot hi core0");
    rd(8'h5C, 32'h0, "R1 boot lo core3");

    // R4 remap: L0->0 L1->2 L2->1 L3->3
    wr(8'h04, 32'hD8);
    rd(8'h04, 32'hD8, "R4 map readback");

    // R5 boot words of physical core 2
    wr(8'h50, 32'h0000_0001);
    wr(8'h54, 32'h8000_1000);
    rd(8'h50, 32'h0000_0001, "R5 hi core2");
    rd(8'h54, 32'h8000_1000, "R5 lo core2");

    // R3 R6 R7: release logical 1 (physical 2)
    coreOff[2] = 1'b0;
    wr(8'h08, 32'h0000_0001);
    chk(64'(coreHalt), 64'hB, "R3 only physical 2 released");
    chk(64'(coreRelease), 64'h4, "R6 strobe on release");
    chk(bootVec[128 +: 64], 64'h0000_0001_8000_1000, "R7 vector captured");
    idle(1);
    chk(64'(coreRelease), 64'h0, "R6 strobe lasts one cycle");

    // R7 rewrite while running
    wr(8'h54, 32'hDEAD_0000);
    idle(2);
    chk(bootVec[128 +: 64], 64'h0000_0001_8000_1000, "R7 vector held");
    rd(8'h54, 32'hDEAD_0000, "R5 lo rewritten");

    // R8 deferred halt
    wr(8'h08, 32'h0000_0101);
    idle(3);
    chk(64'(coreHalt), 64'hB, "R8 halt held back");
    coreOff[2] = 1'b1;
    @(negedge clk);
    chk(64'(coreHalt), 64'hF, "R8 halt after power-down");

    // R2 R8 cancel: release core 3 then request and withdraw halt
    coreOff[3] = 1'b0;
    wr(8'h00, 32'h7);
    chk(64'(coreHalt), 64'h7, "R2 full write releases core3");
    chk(64'(coreRelease), 64'h8, "R6 strobe core3");
    wr(8'h00, 32'hF);
    wr(8'h00, 32'h7);
    chk(64'(coreRelease), 64'h0, "R6 no strobe for running core");
    coreOff[3] = 1'b1;
    idle(2);
    chk(64'(coreHalt), 64'h7, "R8 withdrawn halt stays off");

    // same cycle: deferred halt of 3 completes while logical 2 (phys 1) is released
    coreOff[3] = 1'b0;
    wr(8'h08, 32'h0000_0103);
    coreOff[3] = 1'b1;
    wr(8'h08, 32'h0000_0002);
    chk(64'(coreHalt), 64'hD, "R3 R8 merged update");
    chk(64'(coreRelease), 64'h2, "R6 strobe core1 in merged cycle");
    chk(bootVec[64 +: 64], 64'h0, "R7 vector core1");

    // release wins over halt completing on the same core
    coreOff[1] = 1'b0;
    wr(8'h08, 32'h0000_0102);
    coreOff[1] = 1'b1;
    wr(8'h08, 32'h0000_0002);
    chk(64'(coreRelease), 64'h0, "R8 no strobe when release wins");
    idle(2);
    chk(64'(coreHalt), 64'hD, "R8 release wins");

    // R9 unmapped and ignored accesses
    rd(8'h30, 32'h0, "R9 unmapped read");
    rd(8'h08, 32'h0, "R9 single-bit port reads zero");
    rd(8'h60, 32'h0, "R9 past boot window");
    rd(8'h42, 32'h0, "R9 unaligned read");
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0005);
    chk(64'(coreHalt), 64'hD, "R3 R9 ignored writes leave halt");
    rd(8'h04, 32'hD8, "R9 map untouched");
    rd(8'h40, 32'h0, "R9 boot hi core0 untouched");
    rd(8'h44, 32'h0, "R9 boot lo core0 untouched");

    // R10 hold after read
    idle(3);
    chk(64'(rdData), 64'h0, "R10 rdData held");
    rd(8'h00, 32'hD, "R2 halt readback");
    idle(3);
    chk(64'(rdData), 64'hD, "R10 rdData held after read");

    // R2 R6 R7 multi-core release
    wr(8'h58, 32'h0000_0002);
    wr(8'h5C, 32'h1234_5678);
    wr(8'h00, 32'h0);
    chk(64'(coreHalt), 64'h0, "R2 all released");
    chk(64'(coreRelease), 64'hD, "R6 strobes for halted cores only");
    chk(bootVec[0 +: 64], 64'h0, "R7 vector core0");
    chk(bootVec[128 +: 64], 64'h0000_0001_DEAD_0000, "R7 vector core2 recaptured");
    chk(bootVec[192 +: 64], 64'h0000_0002_1234_5678, "R7 vector core3");
    idle(1);
    chk(64'(coreRelease), 64'h0, "R6 strobes end");

    idle(2);
    chk(64'(expQ.size()), 64'h0, "R10 all reads returned");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule